// File: doc/BRIEF.md
# Spread Slot Mapper with Multi-Vector Interleave

This block sits on both sides of a variable-size circular shifter with N slots. On the way in, it takes a compact vector of m elements and writes element j to slot floor(j·N/L), where L is the logical length. All other slots are left empty, so the occupied slots are spaced as evenly as the ratio allows. This spacing is what lets a plain N-slot rotator, followed by one correction stage, rotate a vector whose length is smaller than N. On the way out, the block reads those same slots back into compact order.

The block can also carry T independent vectors of length m at once, provided T·m does not exceed N. On input the vectors are merged element by element: combined position j = q·T + r holds element q of vector r. The spread then uses L = T·m. A shift of p·T on the merged vector moves each member vector by p. The output direction undoes the merge.

Both directions share one configuration (m, T) and can be strobed independently, including in the same cycle. An illegal configuration is reported instead of mapped. Each result is registered one cycle after its strobe.

Top module: `spread_slot_mapper`

## Requirements
- R1: With T=1 and a legal m, compact element i (bits [i·W +: W] of `map_elems_i`) appears at slot floor(i·N/m) (bits [s·W +: W] of `map_slots_o`). Compact elements at index m or above have no effect on the output.
- R2: After a legal map strobe, every slot not listed by the placement rule reads zero. `map_mask_o` bit s is 1 exactly for the occupied slots, so its population equals T·m.
- R3: With T vectors, vector r element q sits at compact index r·m+q. It is placed as combined position j = q·T + r at slot floor(j·N/(T·m)). For example, with N=8, T=2 and m=3, vector 1 element 0 lands in slot 1.
- R4: A strobe with m < 2, T < 1 or T·m > N raises the error output of that direction. In that case all data and mask outputs of that direction are zero.
- R5: A direction's valid output pulses high exactly in the cycle after its strobe, with its new result. Without a strobe, that direction's data, mask and error outputs hold their values.
- R6: After an output-direction strobe, `unm_elems_o` holds, at compact index r·m+q, the content of slot floor((q·T+r)·N/(T·m)). Compact indices at or above T·m read zero, and the contents of unoccupied slots have no effect.
- R7: Passing a legal map result back through the output direction with the same configuration returns the original compact elements below index T·m.
- R8: While reset is high, and in the cycle after reset, all valid, error, data and mask outputs are zero.
- R9: Strobes to both directions in the same cycle each produce their own correct result in the following cycle, with no interference between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_m | input | CW = $clog2(N+1) | Length m of each vector |
| cfg_t | input | CW | Number T of interleaved vectors |
| map_valid_i | input | 1 | Strobe for the input (spread) direction |
| map_elems_i | input | N*W | Compact elements, index e at bits [e·W +: W] |
| unm_valid_i | input | 1 | Strobe for the output (gather) direction |
| unm_slots_i | input | N*W | N-slot word to gather from |
| map_vld_o | output | 1 | Spread result valid |
| map_err_o | output | 1 | Configuration was illegal at the last spread strobe |
| map_slots_o | output | N*W | Spread N-slot word |
| map_mask_o | output | N | Occupied-slot mask |
| unm_vld_o | output | 1 | Gather result valid |
| unm_err_o | output | 1 | Configuration was illegal at the last gather strobe |
| unm_elems_o | output | N*W | Gathered compact elements |

## Verification
The spread and the gather can be strobed in the same cycle with the same configuration. The bench strobes both together for every (m, T) pair the configuration inputs can encode. It fills the gather input with non-zero values in every slot, so that a gather that reads an empty slot, or that depends on the spread path, shows up as a wrong compact value. Both registered results are compared in the following cycle with values the bench derives arithmetically. Each legal spread result is then fed back alone through the gather, and the original elements must return.

// File: rtl/smap_pkg.sv
package smap_pkg;

    typedef enum logic {
        ILV_JOIN  = 1'b0,
        ILV_SPLIT = 1'b1
    } ilv_dir_e;

    // slot that receives combined position j when len positions are spread over n slots
    function automatic int slot_of(input int j, input int n, input int len);
        if (len <= 0) return 0;
        return (j * n) / len;
    endfunction

    // compact index (vector r, element q) paired with combined position j = q*t + r
    function automatic int compact_of(input int j, input int m, input int t);
        if (t <= 0) return 0;
        return (j % t) * m + (j / t);
    endfunction

endpackage

// File: rtl/smap_cfg_check.sv
module smap_cfg_check #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [CW-1:0]   cfg_m,
    input  logic [CW-1:0]   cfg_t,
    output logic            cfg_ok,
    output logic [2*CW-1:0] cfg_len
);
    localparam int LW = 2 * CW;

    always_comb begin
        cfg_len = LW'(cfg_m) * LW'(cfg_t);
        cfg_ok  = (cfg_m >= CW'(2)) && (cfg_t != '0) && (cfg_len <= LW'(N));
    end

endmodule

// File: rtl/smap_ileave.sv
module smap_ileave
    import smap_pkg::*;
#(
    parameter int       N   = 8,
    parameter int       W   = 8,
    parameter int       CW  = $clog2(N + 1),
    parameter ilv_dir_e DIR = ILV_JOIN
) (
    input  logic            ok,
    input  logic [CW-1:0]   cfg_m,
    input  logic [CW-1:0]   cfg_t,
    input  logic [2*CW-1:0] len,
    input  logic [N*W-1:0]  din,
    output logic [N*W-1:0]  dout
);

    generate
        if (DIR == ILV_JOIN) begin : g_join
            // combined position j takes compact element compact_of(j)
            always_comb begin
                dout = '0;
                if (ok) begin
                    for (int j = 0; j < N; j++) begin
                        if (j < int'(len) &&
                            compact_of(j, int'(cfg_m), int'(cfg_t)) < N) begin
                            dout[j*W +: W] =
                                din[compact_of(j, int'(cfg_m), int'(cfg_t))*W +: W];
                        end
                    end
                end
            end
        end else begin : g_split
            // compact element compact_of(j) takes combined position j
            always_comb begin
                dout = '0;
                if (ok) begin
                    for (int j = 0; j < N; j++) begin
                        if (j < int'(len) &&
                            compact_of(j, int'(cfg_m), int'(cfg_t)) < N) begin
                            dout[compact_of(j, int'(cfg_m), int'(cfg_t))*W +: W] =
                                din[j*W +: W];
                        end
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/smap_scatter.sv
module smap_scatter
    import smap_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic            ok,
    input  logic [2*CW-1:0] len,
    input  logic [N*W-1:0]  din,
    output logic [N*W-1:0]  slots,
    output logic [N-1:0]    mask
);

    always_comb begin
        slots = '0;
        mask  = '0;
        if (ok) begin
            for (int j = 0; j < N; j++) begin
                if (j < int'(len)) begin
                    slots[slot_of(j, N, int'(len))*W +: W] = din[j*W +: W];
                    mask[slot_of(j, N, int'(len))]         = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/smap_gather.sv
module smap_gather
    import smap_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic            ok,
    input  logic [2*CW-1:0] len,
    input  logic [N*W-1:0]  slots,
    output logic [N*W-1:0]  dout
);

    always_comb begin
        dout = '0;
        if (ok) begin
            for (int j = 0; j < N; j++) begin
                if (j < int'(len)) begin
                    dout[j*W +: W] = slots[slot_of(j, N, int'(len))*W +: W];
                end
            end
        end
    end

endmodule

// File: rtl/spread_slot_mapper.sv
module spread_slot_mapper
    import smap_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW-1:0]   cfg_m,
    input  logic [CW-1:0]   cfg_t,
    input  logic            map_valid_i,
    input  logic [N*W-1:0]  map_elems_i,
    input  logic            unm_valid_i,
    input  logic [N*W-1:0]  unm_slots_i,
    output logic            map_vld_o,
    output logic            map_err_o,
    output logic [N*W-1:0]  map_slots_o,
    output logic [N-1:0]    map_mask_o,
    output logic            unm_vld_o,
    output logic            unm_err_o,
    output logic [N*W-1:0]  unm_elems_o
);
    localparam int LW = 2 * CW;

    logic          cfg_ok;
    logic [LW-1:0] cfg_len;

    logic [N*W-1:0] join_vec;
    logic [N*W-1:0] sc_slots;
    logic [N-1:0]   sc_mask;
    logic [N*W-1:0] ga_vec;
    logic [N*W-1:0] split_vec;

    smap_cfg_check #(.N(N), .CW(CW)) u_cfg (
        .cfg_m   (cfg_m),
        .cfg_t   (cfg_t),
        .cfg_ok  (cfg_ok),
        .cfg_len (cfg_len)
    );

    // spread direction: interleave, then scatter
    smap_ileave #(.N(N), .W(W), .CW(CW), .DIR(ILV_JOIN)) u_join (
        .ok    (cfg_ok),
        .cfg_m (cfg_m),
        .cfg_t (cfg_t),
        .len   (cfg_len),
        .din   (map_elems_i),
        .dout  (join_vec)
    );

    smap_scatter #(.N(N), .W(W), .CW(CW)) u_scatter (
        .ok    (cfg_ok),
        .len   (cfg_len),
        .din   (join_vec),
        .slots (sc_slots),
        .mask  (sc_mask)
    );

    // gather direction: gather, then de-interleave
    smap_gather #(.N(N), .W(W), .CW(CW)) u_gather (
        .ok    (cfg_ok),
        .len   (cfg_len),
        .slots (unm_slots_i),
        .dout  (ga_vec)
    );

    smap_ileave #(.N(N), .W(W), .CW(CW), .DIR(ILV_SPLIT)) u_split (
        .ok    (cfg_ok),
        .cfg_m (cfg_m),
        .cfg_t (cfg_t),
        .len   (cfg_len),
        .din   (ga_vec),
        .dout  (split_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            map_vld_o   <= 1'b0;
            map_err_o   <= 1'b0;
            map_slots_o <= '0;
            map_mask_o  <= '0;
        end else begin
            map_vld_o <= map_valid_i;
            if (map_valid_i) begin
                map_err_o   <= !cfg_ok;
                map_slots_o <= cfg_ok ? sc_slots : '0;
                map_mask_o  <= cfg_ok ? sc_mask  : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unm_vld_o   <= 1'b0;
            unm_err_o   <= 1'b0;
            unm_elems_o <= '0;
        end else begin
            unm_vld_o <= unm_valid_i;
            if (unm_valid_i) begin
                unm_err_o   <= !cfg_ok;
                unm_elems_o <= cfg_ok ? split_vec : '0;
            end
        end
    end

    // mask widened to slot bits, for the idle-slot check
    logic [N*W-1:0] mask_wide;
    generate
        for (genvar s = 0; s < N; s++) begin : g_mw
            assign mask_wide[s*W +: W] = {W{map_mask_o[s]}};
        end
    endgenerate

    // R2: no data outside the occupied slots
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (map_slots_o & ~mask_wide) == '0);

    // R2: occupied count equals T*m of the strobed configuration
    a_r2_mask_count: assert property (@(posedge clk) disable iff (rst)
        (map_valid_i && cfg_ok) |=> ($countones(map_mask_o) == int'($past(cfg_len))));

    // R4: an error leaves the spread outputs blank
    a_r4_err_blank: assert property (@(posedge clk) disable iff (rst)
        map_err_o |-> (map_mask_o == '0 && map_slots_o == '0));

    // R4: an error leaves the gather output blank
    a_r4_unm_err_blank: assert property (@(posedge clk) disable iff (rst)
        unm_err_o |-> (unm_elems_o == '0));

    // R5: strobe yields a valid pulse next cycle
    a_r5_map_pulse: assert property (@(posedge clk) disable iff (rst)
        map_valid_i |=> map_vld_o);

    // R5: without a strobe the spread word holds
    a_r5_map_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(map_valid_i)) |-> $stable(map_slots_o));

    // R9: simultaneous strobes both answer
    a_r9_both: assert property (@(posedge clk) disable iff (rst)
        (map_valid_i && unm_valid_i) |=> (map_vld_o && unm_vld_o));

endmodule

// File: tb/tb_spread_slot_mapper.sv
`timescale 1ns/1ps
module tb_spread_slot_mapper;
    localparam int N  = 8;
    localparam int W  = 8;
    localparam int CW = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [CW-1:0]   cfg_m = '0;
    logic [CW-1:0]   cfg_t = '0;
    logic            map_valid_i = 1'b0;
    logic [N*W-1:0]  map_elems_i = '0;
    logic            unm_valid_i = 1'b0;
    logic [N*W-1:0]  unm_slots_i = '0;
    logic            map_vld_o, map_err_o, unm_vld_o, unm_err_o;
    logic [N*W-1:0]  map_slots_o, unm_elems_o;
    logic [N-1:0]    map_mask_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    spread_slot_mapper #(.N(N), .W(W), .CW(CW)) dut (
        .clk, .rst, .cfg_m, .cfg_t,
        .map_valid_i, .map_elems_i, .unm_valid_i, .unm_slots_i,
        .map_vld_o, .map_err_o, .map_slots_o, .map_mask_o,
        .unm_vld_o, .unm_err_o, .unm_elems_o
    );

    task automatic check(input bit good, input string req,
                         input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        tests++;
        if (!good) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit legal(input int m, input int t);
        return (m >= 2) && (t >= 1) && (m * t <= N);
    endfunction

    // expected spread word: vector r elem q at compact r*m+q -> slot ((q*t+r)*N)/(t*m)
    function automatic logic [N*W-1:0] exp_slots(input int m, input int t,
                                                 input logic [N*W-1:0] d);
        logic [N*W-1:0] o = '0;
        if (legal(m, t))
            for (int r = 0; r < t; r++)
                for (int q = 0; q < m; q++)
                    o[(((q*t + r) * N) / (t*m))*W +: W] = d[(r*m + q)*W +: W];
        return o;
    endfunction

    function automatic logic [N-1:0] exp_mask(input int m, input int t);
        logic [N-1:0] o = '0;
        if (legal(m, t))
            for (int k = 0; k < t*m; k++) o[(k * N) / (t*m)] = 1'b1;
        return o;
    endfunction

    function automatic logic [N*W-1:0] exp_gather(input int m, input int t,
                                                  input logic [N*W-1:0] s);
        logic [N*W-1:0] o = '0;
        if (legal(m, t))
            for (int r = 0; r < t; r++)
                for (int q = 0; q < m; q++)
                    o[(r*m + q)*W +: W] = s[(((q*t + r) * N) / (t*m))*W +: W];
        return o;
    endfunction

    function automatic logic [N*W-1:0] keep_low(input int len, input logic [N*W-1:0] d);
        logic [N*W-1:0] o = '0;
        for (int e = 0; e < N; e++) if (e < len) o[e*W +: W] = d[e*W +: W];
        return o;
    endfunction

    initial begin
        #(5.0 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [N*W-1:0] din, sl, held, mexp, gexp;
        logic [N-1:0]   kexp;
        bit ok;

        repeat (3) @(negedge clk);
        // R8: reset state
        check(map_vld_o == 0 && unm_vld_o == 0 && map_err_o == 0 && unm_err_o == 0,
              "R8 flags in reset", {62'd0, map_vld_o, unm_vld_o}, '0);
        check(map_slots_o == '0 && unm_elems_o == '0 && map_mask_o == '0,
              "R8 data in reset", map_slots_o | unm_elems_o, '0);
        rst = 1'b0;
        @(negedge clk);
        check(map_vld_o == 0 && unm_vld_o == 0 && map_slots_o == '0,
              "R8 after reset", map_slots_o, '0);

        for (int m = 0; m < (1 << CW); m++) begin
            for (int t = 0; t < (1 << CW); t++) begin
                ok = legal(m, t);
                for (int e = 0; e < N; e++) begin
                    din[e*W +: W] = W'(m*37 + t*13 + e*11 + 1);
                    sl[e*W +: W]  = W'(8'h80 | (m*5 + t*3 + e*7));
                end
                // R9: both directions strobed together
                cfg_m = CW'(m); cfg_t = CW'(t);
                map_elems_i = din; unm_slots_i = sl;
                map_valid_i = 1'b1; unm_valid_i = 1'b1;
                @(negedge clk);
                map_valid_i = 1'b0; unm_valid_i = 1'b0;
                mexp = exp_slots(m, t, din);
                kexp = exp_mask(m, t);
                gexp = exp_gather(m, t, sl);
                check(map_vld_o && unm_vld_o, "R5 R9 valid pulse",
                      {62'd0, map_vld_o, unm_vld_o}, 64'd3);
                check(map_err_o == !ok && unm_err_o == !ok, "R4 error flag",
                      {62'd0, map_err_o, unm_err_o}, {62'd0, !ok, !ok});
                // R1 R3 placement, R2 idle zero
                check(map_slots_o == mexp, (t == 1) ? "R1 spread placement" : "R3 interleave placement",
                      map_slots_o, mexp);
                check(map_mask_o == kexp, "R2 occupied mask",
                      {56'd0, map_mask_o}, {56'd0, kexp});
                // R6 gather ignores idle slots (filled non-zero)
                check(unm_elems_o == gexp, "R6 gather and split", unm_elems_o, gexp);
                held = map_slots_o;
                @(negedge clk);
                check(!map_vld_o && !unm_vld_o && map_slots_o == held,
                      "R5 hold without strobe", map_slots_o, held);
                if (ok) begin
                    // R7 round trip
                    unm_slots_i = held;
                    unm_valid_i = 1'b1;
                    @(negedge clk);
                    unm_valid_i = 1'b0;
                    check(unm_elems_o == keep_low(m*t, din), "R7 round trip",
                          unm_elems_o, keep_low(m*t, din));
                    check(map_slots_o == held && !map_vld_o, "R5 spread untouched by gather",
                          map_slots_o, held);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule